// File: doc/BRIEF.md
# Quad-Nibble Serial Command Front End

This block is the device-side receiver for a four-wire-data serial flash link. While the select line is held low, it takes one nibble from the four data pins on each rising serial-clock edge and pairs the nibbles into bytes, with the high nibble first. The first byte is the opcode. For the erase and program opcodes, three address bytes follow the opcode and are packed into a 24-bit address. For a page program, every later byte is handed to the core as a data byte. The core sees single-cycle strobes together with the opcode, the address and the data byte.

For the identification opcode, the block turns the data pins around. On each falling serial-clock edge it drives the next nibble of a three-byte identity (manufacturer, type, device). The readout wraps around after the last byte and continues until the select line rises. An unknown opcode makes the block deaf for the rest of the transaction. Raising the select line always returns the block to waiting for an opcode.

The serial pins are assumed to be already synchronous to `clk`, which runs several times faster than the serial clock. Serial-clock edges are found by comparing each sample with the previous one.

Top module: `qsf_front_end`

## Requirements
- R1: After a synchronous active-low reset with the select line high, `cmd_valid`, `addr_valid`, `data_valid` and `sio_oe` are all 0.
- R2: Two rising serial-clock edges form one byte, with the first nibble as bits [7:4]. For the opcodes 20h, D8h, 02h, C7h and AFh, the first byte of a transaction produces a one-cycle `cmd_valid` with `cmd_op` equal to that byte, in the clock after the second rising edge.
- R3: After 20h, D8h or 02h, the next six nibbles form a 24-bit address, most significant nibble first. `addr_valid` pulses once with `addr` holding it, in the clock after the sixth nibble.
- R4: Opcode C7h takes no address. Every further nibble in that transaction produces no `addr_valid` and no `data_valid`.
- R5: After the address of 02h, each later nibble pair produces one `data_valid` pulse with `data` equal to that byte, with no limit on the count. The opcodes 20h and D8h produce no data strobes.
- R6: A trailing unpaired nibble produces no strobe. The next transaction starts again at the high nibble.
- R7: After AFh, `sio_oe` is 1. Each falling serial-clock edge loads `sio_out` with the next nibble of the sequence BFh, 26h, DEV_ID (high nibble first), wrapping around indefinitely. Before the first falling edge, `sio_out` is 0.
- R8: `sio_oe` returns to 0 in the same clock cycle that the select line goes high, with no register delay.
- R9: An unrecognised opcode produces no strobe and no output enable for the rest of that transaction.
- R10: Raising the select line mid-command discards partial nibbles and address bytes. The next transaction decodes from scratch.
- R11: Serial-clock edges seen while the select line is high produce no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversampling the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock, sampled |
| cs_n | input | 1 | Select, active low |
| sio_in | input | 4 | Nibble arriving on the data pins |
| sio_out | output | 4 | Nibble driven onto the data pins |
| sio_oe | output | 1 | Output enable for the data pins |
| cmd_valid | output | 1 | One-cycle strobe for a recognised opcode |
| cmd_op | output | 8 | Last recognised opcode |
| addr_valid | output | 1 | One-cycle strobe for a complete address |
| addr | output | ADDR_W | Assembled address |
| data_valid | output | 1 | One-cycle strobe for a program data byte |
| data | output | 8 | Program data byte |

## Verification
The bench targets four corner cases:
- **Aborted address.** A transaction is aborted after two of its three address bytes. A design that kept the stale bytes would report a shifted, wrong address in the next erase.
- **Odd trailing nibble.** A page program ends on an odd nibble and is followed by a fresh opcode. A design that kept the half byte would misread that opcode and never strobe it.
- **Identity wrap.** The identity readout runs past its sixth nibble. A wrong wrap would repeat a nibble or emit a stale value, and the falling-edge samples would stop matching the wrapped sequence.
- **Ignored traffic.** Clocking with the select line high, traffic after an unknown opcode and traffic after chip erase must all stay silent. A spurious address or data strobe here would erase or program the wrong place.

// File: rtl/qsf_pkg.sv
// Shared opcodes, phase type and decode helpers for the quad-nibble front end.
package qsf_pkg;

    localparam logic [7:0] OP_SECT_ERASE  = 8'h20;
    localparam logic [7:0] OP_BLOCK_ERASE = 8'hD8;
    localparam logic [7:0] OP_PAGE_PROG   = 8'h02;
    localparam logic [7:0] OP_CHIP_ERASE  = 8'hC7;
    localparam logic [7:0] OP_IDENT_READ  = 8'hAF;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_DATA,
        PH_IDENT,
        PH_SKIP
    } phase_e;

    // True when the opcode is followed by address cycles.
    function automatic logic takes_addr(input logic [7:0] op);
        return (op == OP_SECT_ERASE) || (op == OP_BLOCK_ERASE) || (op == OP_PAGE_PROG);
    endfunction

    // True for every opcode this front end recognises.
    function automatic logic is_known(input logic [7:0] op);
        return takes_addr(op) || (op == OP_CHIP_ERASE) || (op == OP_IDENT_READ);
    endfunction

endpackage

// File: rtl/qsf_sck_edge.sv
// Finds rising and falling edges of the sampled serial clock.
// Assumes sck is already synchronous to clk and held for at least one clk per level.
module qsf_sck_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic rise,
    output logic fall
);
    logic sck_q;

    // Remember the previous serial clock sample.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign rise = sck & ~sck_q;
    assign fall = ~sck & sck_q;

endmodule

// File: rtl/qsf_nibble_pair.sv
// Pairs incoming nibbles into bytes, first nibble in the upper half.
// Assumes clear is held whenever the link is deselected.
module qsf_nibble_pair #(
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               take,
    input  logic [NIB_W-1:0]   nib,
    output logic               byte_done,
    output logic [2*NIB_W-1:0] byte_val
);
    logic             half;
    logic [NIB_W-1:0] hi_q;

    // Hold the upper nibble and track which half is next.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            half <= 1'b0;
            hi_q <= '0;
        end else if (take) begin
            half <= ~half;
            if (!half) hi_q <= nib;
        end
    end

    assign byte_done = take & half;
    assign byte_val  = {hi_q, nib};

    // A byte can only complete when the upper half was already taken.
    p_pair_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(half) || $past(take));

endmodule

// File: rtl/qsf_id_driver.sv
// Steps through the identity nibbles, wrapping around after the last one.
// Assumes step arrives on falling serial-clock edges during the identity phase.
module qsf_id_driver #(
    parameter int ID_BYTES = 3,
    parameter logic [8*ID_BYTES-1:0] ID_WORD = 24'hBF2641
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       step,
    output logic [3:0] nib
);
    localparam int NIBS  = 2 * ID_BYTES;
    localparam int IDX_W = $clog2(NIBS);
    localparam int TAB_N = 2 ** IDX_W;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NIBS - 1);

    logic [IDX_W-1:0] idx;
    logic [3:0]       tab [TAB_N];

    // Split the identity word into nibbles, most significant first.
    for (genvar g = 0; g < TAB_N; g++) begin : g_tab
        if (g < NIBS) begin : g_used
            assign tab[g] = ID_WORD[4*(NIBS-1-g) +: 4];
        end else begin : g_pad
            assign tab[g] = 4'h0;
        end
    end

    // Load the next nibble on each step and wrap the index.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx <= '0;
            nib <= 4'h0;
        end else if (step) begin
            nib <= tab[idx];
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end

    p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST);

endmodule

// File: rtl/qsf_front_end.sv
// Device-side quad-nibble command front end: decodes opcode, address and
// program data, and drives the identity readout.
// Assumes the serial pins are synchronous to clk, with clk several times faster than sck.
module qsf_front_end
    import qsf_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter logic [7:0] MFR_ID  = 8'hBF,
    parameter logic [7:0] TYPE_ID = 8'h26,
    parameter logic [7:0] DEV_ID  = 8'h41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic [3:0]        sio_in,
    output logic [3:0]        sio_out,
    output logic              sio_oe,
    output logic              cmd_valid,
    output logic [7:0]        cmd_op,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr,
    output logic              data_valid,
    output logic [7:0]        data
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_AB = CNT_W'(ADDR_BYTES - 1);

    logic             rise, fall;
    logic             byte_done;
    logic [7:0]       byte_val;
    phase_e           phase;
    logic [CNT_W-1:0] addr_cnt;
    logic             id_step;

    qsf_sck_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sck   (sck),
        .rise  (rise),
        .fall  (fall)
    );

    qsf_nibble_pair #(.NIB_W(4)) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cs_n),
        .take      (rise & ~cs_n),
        .nib       (sio_in),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    assign id_step = fall & ~cs_n & (phase == PH_IDENT);

    qsf_id_driver #(.ID_BYTES(3), .ID_WORD({MFR_ID, TYPE_ID, DEV_ID})) u_id (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cs_n),
        .step  (id_step),
        .nib   (sio_out)
    );

    // Transaction sequencer: phase, address shifting and core strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            phase      <= PH_CMD;
            addr_cnt   <= '0;
            addr       <= '0;
            cmd_valid  <= 1'b0;
            addr_valid <= 1'b0;
            data_valid <= 1'b0;
        end else begin
            cmd_valid  <= 1'b0;
            addr_valid <= 1'b0;
            data_valid <= 1'b0;
            if (byte_done) begin
                unique case (phase)
                    PH_CMD: begin
                        if (is_known(byte_val)) begin
                            cmd_valid <= 1'b1;
                            if (takes_addr(byte_val))          phase <= PH_ADDR;
                            else if (byte_val == OP_IDENT_READ) phase <= PH_IDENT;
                            else                               phase <= PH_SKIP;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end
                    PH_ADDR: begin
                        addr <= {addr[ADDR_W-9:0], byte_val};
                        if (addr_cnt == LAST_AB) begin
                            addr_valid <= 1'b1;
                            phase <= (cmd_op == OP_PAGE_PROG) ? PH_DATA : PH_SKIP;
                        end else begin
                            addr_cnt <= addr_cnt + 1'b1;
                        end
                    end
                    PH_DATA: data_valid <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // Capture the recognised opcode and each program byte for the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_op <= 8'h00;
            data   <= 8'h00;
        end else if (!cs_n && byte_done) begin
            if (phase == PH_CMD && is_known(byte_val)) cmd_op <= byte_val;
            if (phase == PH_DATA)                      data   <= byte_val;
        end
    end

    // Drive the data pins only in the identity phase; drop at once on deselect.
    assign sio_oe = (phase == PH_IDENT) & ~cs_n;

    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, addr_valid, data_valid}));
    p_cmd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    p_addr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> !addr_valid);
    p_data_prog_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> cmd_op == OP_PAGE_PROG);
    p_oe_after_ident_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sio_oe) |-> cmd_valid && cmd_op == OP_IDENT_READ);
    p_quiet_deselected_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !cmd_valid && !addr_valid && !data_valid);

endmodule

// File: tb/qsf_front_end_test.sv
module qsf_front_end_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic [3:0]  sio_in = 4'h0;
    logic [3:0]  sio_out;
    logic        sio_oe;
    logic        cmd_valid, addr_valid, data_valid;
    logic [7:0]  cmd_op, data;
    logic [23:0] addr;

    qsf_front_end uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sio_in(sio_in),
        .sio_out(sio_out), .sio_oe(sio_oe), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .addr_valid(addr_valid), .addr(addr), .data_valid(data_valid), .data(data)
    );

    always #10 clk = ~clk;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // Reference model state.
    localparam int S_CMD = 0, S_ADDR = 1, S_DATA = 2, S_ID = 3, S_SKIP = 4;
    byte unsigned id_bytes [3] = '{8'hBF, 8'h26, 8'h41};
    int   m_st = S_CMD, m_idx = 0;
    bit   m_prev = 0, m_half = 0;
    logic [3:0]  m_hi = 0, m_out = 0;
    logic [7:0]  m_op = 0;
    byte unsigned addr_q [$];
    bit   e_cmd, e_addr, e_data;
    logic [7:0]  e_op, e_d;
    logic [23:0] e_a;

    // Scenario observations.
    int n_cmd, n_addr, n_data;
    logic [23:0] last_addr;
    byte unsigned got_data [$];
    logic [3:0] last_out;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [3:0] id_nib(input int i);
        return (i % 2 == 0) ? id_bytes[i/2][7:4] : id_bytes[i/2][3:0];
    endfunction

    function automatic void consume(input logic [7:0] b);
        bit known = (b == 8'h20 || b == 8'hD8 || b == 8'h02 || b == 8'hC7 || b == 8'hAF);
        case (m_st)
            S_CMD: begin
                if (known) begin
                    e_cmd = 1; e_op = b; m_op = b;
                    if (b == 8'h20 || b == 8'hD8 || b == 8'h02) m_st = S_ADDR;
                    else if (b == 8'hAF) m_st = S_ID;
                    else m_st = S_SKIP;
                end else m_st = S_SKIP;
            end
            S_ADDR: begin
                addr_q.push_back(b);
                if (addr_q.size() == 3) begin
                    e_addr = 1; e_a = {addr_q[0], addr_q[1], addr_q[2]};
                    m_st = (m_op == 8'h02) ? S_DATA : S_SKIP;
                end
            end
            S_DATA: begin e_data = 1; e_d = b; end
            default: ;
        endcase
    endfunction

    // One clk cycle: advance the model with the present inputs, then compare.
    task automatic cyc();
        bit rise = sck && !m_prev;
        bit fall = !sck && m_prev;
        bit e_oe;
        e_cmd = 0; e_addr = 0; e_data = 0;
        if (!rst_n) begin
            m_st = S_CMD; m_half = 0; m_hi = 0; addr_q.delete(); m_idx = 0; m_out = 0;
        end else if (cs_n) begin
            m_st = S_CMD; m_half = 0; m_hi = 0; addr_q.delete(); m_idx = 0; m_out = 0;
        end else begin
            if (rise) begin
                if (m_half) begin m_half = 0; consume({m_hi, sio_in}); end
                else begin m_hi = sio_in; m_half = 1; end
            end
            if (fall && m_st == S_ID) begin
                m_out = id_nib(m_idx); m_idx = (m_idx + 1) % 6;
            end
        end
        m_prev = rst_n ? sck : 1'b0;
        e_oe = (m_st == S_ID) && !cs_n;
        @(posedge clk);
        #5;
        chk(cmd_valid === e_cmd, cur_req, "cmd_valid", cmd_valid, e_cmd);
        chk(addr_valid === e_addr, cur_req, "addr_valid", addr_valid, e_addr);
        chk(data_valid === e_data, cur_req, "data_valid", data_valid, e_data);
        chk(sio_oe === e_oe, cur_req, "sio_oe", sio_oe, e_oe);
        if (e_cmd)  chk(cmd_op === e_op, cur_req, "cmd_op", cmd_op, e_op);
        if (e_addr) chk(addr === e_a, cur_req, "addr", addr, e_a);
        if (e_data) chk(data === e_d, cur_req, "data", data, e_d);
        if (e_oe)   chk(sio_out === m_out, cur_req, "sio_out", sio_out, m_out);
        if (cmd_valid)  n_cmd++;
        if (addr_valid) begin n_addr++; last_addr = addr; end
        if (data_valid) begin n_data++; got_data.push_back(data); end
    endtask

    task automatic nib_clk(input logic [3:0] n);
        sck = 1'b0; sio_in = n;
        cyc(); cyc();
        last_out = sio_out;
        sck = 1'b1;
        cyc(); cyc();
    endtask

    task automatic send(input logic [7:0] b);
        nib_clk(b[7:4]); nib_clk(b[3:0]);
    endtask

    task automatic start_tx(input string req);
        cur_req = req; n_cmd = 0; n_addr = 0; n_data = 0; got_data.delete();
        cs_n = 1'b0; sck = 1'b0; cyc(); cyc();
    endtask

    task automatic stop_tx();
        sck = 1'b0; cyc();
        cs_n = 1'b1; cyc(); cyc();
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired in %s", cur_req);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc(); cyc();
        chk(cmd_valid === 0 && addr_valid === 0 && data_valid === 0, "R1", "strobes", 0, 0);
        chk(sio_oe === 0, "R1", "sio_oe", sio_oe, 0);

        // R2 R3: sector erase with address
        start_tx("R3");
        send(8'h20); send(8'h12); send(8'h34); send(8'h56);
        stop_tx();
        chk(n_cmd == 1, "R2", "sector cmd count", n_cmd, 1);
        chk(n_addr == 1 && last_addr == 24'h123456, "R3", "sector addr", last_addr, 24'h123456);

        // R3 R5: block erase, trailing bytes give no data
        start_tx("R5");
        send(8'hD8); send(8'hAB); send(8'hCD); send(8'hEF); send(8'h99); send(8'h11);
        stop_tx();
        chk(last_addr == 24'hABCDEF, "R3", "block addr", last_addr, 24'hABCDEF);
        chk(n_data == 0, "R5", "block data count", n_data, 0);

        // R5 R6: page program with an odd trailing nibble
        start_tx("R6");
        send(8'h02); send(8'h00); send(8'h00); send(8'hF0);
        send(8'hA5); send(8'h3C); send(8'h7E); nib_clk(4'h9);
        stop_tx();
        chk(n_data == 3, "R6", "prog data count", n_data, 3);
        chk(got_data.size() == 3 && got_data[0] == 8'hA5 && got_data[2] == 8'h7E,
            "R5", "prog data", got_data.size() > 0 ? got_data[0] : 0, 8'hA5);
        start_tx("R6");
        send(8'hC7);
        stop_tx();
        chk(n_cmd == 1, "R6", "aligned after odd nibble", n_cmd, 1);

        // R4: chip erase, later nibbles ignored
        start_tx("R4");
        send(8'hC7); send(8'h20); send(8'h01); send(8'h02); send(8'h03);
        stop_tx();
        chk(n_cmd == 1 && n_addr == 0 && n_data == 0, "R4", "chip erase strobes",
            n_addr + n_data, 0);

        // R7 R8: identity readout wraps
        start_tx("R7");
        send(8'hAF);
        for (int i = 0; i < 14; i++) begin
            nib_clk(4'h0);
            chk(last_out === id_nib(i % 6), "R7", "ident nibble", last_out, id_nib(i % 6));
        end
        sck = 1'b0; cyc();
        cs_n = 1'b1; #1;
        chk(sio_oe === 0, "R8", "oe on deselect", sio_oe, 0);
        cur_req = "R8"; cyc(); cyc();

        // R9: unknown opcode mutes the transaction
        start_tx("R9");
        send(8'h5A); send(8'h20); send(8'h12); send(8'h34); send(8'h56); send(8'hAF);
        chk(sio_oe === 0, "R9", "oe after unknown", sio_oe, 0);
        stop_tx();
        chk(n_cmd == 0 && n_addr == 0, "R9", "unknown strobes", n_cmd + n_addr, 0);

        // R10: abort mid-address, then clean decode
        start_tx("R10");
        send(8'h20); send(8'hDE); send(8'hAD); nib_clk(4'h7);
        stop_tx();
        chk(n_addr == 0, "R10", "aborted addr", n_addr, 0);
        start_tx("R10");
        send(8'h20); send(8'h00); send(8'h10); send(8'h00);
        stop_tx();
        chk(n_addr == 1 && last_addr == 24'h001000, "R10", "addr after abort",
            last_addr, 24'h001000);

        // R11: clocking while deselected
        cur_req = "R11"; n_cmd = 0; n_addr = 0; n_data = 0;
        for (int i = 0; i < 8; i++) nib_clk(4'hC);
        chk(n_cmd == 0 && n_addr == 0 && n_data == 0, "R11", "deselected strobes", n_cmd, 0);
        start_tx("R11");
        send(8'hAF); nib_clk(4'h0);
        chk(last_out === 4'hB, "R11", "fresh ident start", last_out, 4'hB);
        stop_tx();

        done = 1'b1;
        finish_run();
    end
endmodule